// File: doc/BRIEF.md
# Tightly Coupled Memory Address Decoder

This block keeps the two setting registers that place a processor's instruction-side and data-side tightly coupled memories in the address map. From each stored setting and its enable bit it derives a window: a base, a mask and a size in bytes. It then classifies a 32-bit address, combinationally, as falling inside the data window, the instruction window, or neither. Software-visible readback returns either stored setting or a constant that reports how large the two memories physically are.

The size of each window is 512 bytes times a power of two, taken from a five-bit exponent field at bits [5:1] of the setting. The field saturates at 23, which gives a 4 GiB window. The data window never shrinks below 4 KiB and can be placed anywhere on a boundary of its own size. The instruction window always starts at address zero. A window whose enable bit is clear is parked: its size is zero, its mask is zero and its base is all ones, so no address can hit it.

A three-state sequencer controls when the derived values are loaded. `ST_LOAD` is the state after reset and loads the derived registers once. `ST_HOLD` keeps them. `ST_REFRESH` reloads them from the current settings and enables. From any state, a setting write or a change on either enable input moves the sequencer to `ST_REFRESH` (transition "dirty"). Otherwise it moves to `ST_HOLD` (transition "quiet"). The derived values, and with them the hit outputs, therefore change on the second clock edge after the write or enable change.

Top module: `tcm_decoder`

## Requirements
- R1: After reset, both setting readbacks are 0, both windows are parked, and both hit outputs are 0.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata & 32'hFFFF_F03E` into the data setting and leaves the instruction setting and the instruction window unchanged.
- R3: A write with `cfg_sel`=1 stores `cfg_wdata & 32'h0000_003E` into the instruction setting and leaves the data window unchanged.
- R4: `rd_sel` 0 returns the data setting, 1 returns the instruction setting, 2 returns the constant 32'h0014_0180 (32 KiB instruction, 16 KiB data), and 3 returns 0.
- R5: With the data window enabled, `d_size` = 512 << max(3, min(f, 23)), where f is data setting bits [5:1].
- R6: With the data window enabled, `d_mask` = 32'hFFFF_F000 & ~(d_size-1), taken over 32 bits (so a 4 GiB size gives mask 0), and `d_base` = data setting & `d_mask`.
- R7: `d_hit` is 1 exactly when the data window is enabled and (`addr` & `d_mask`) equals `d_base`.
- R8: With the instruction window enabled, `i_size` = 512 << min(f, 23) (no lower clamp), `i_base` = 0, `i_mask` = 0, and `i_hit` is 1 exactly when `addr` < `i_size`.
- R9: `tcm_en[0]` (control bit 16) enables the data window and `tcm_en[1]` (control bit 18) enables the instruction window. A disabled window shows size 0, mask 0 and base 32'hFFFF_FFFF, its hit is 0, and its stored setting is kept and reused when it is enabled again.
- R10: After a setting write or an enable change at clock edge k, the derived outputs still show their old values between edges k and k+1 and show the new values after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | Write target: 0 data setting, 1 instruction setting |
| cfg_wdata | input | 32 | Setting write data |
| tcm_en | input | 2 | Enable bits: [0] data (control bit 16), [1] instruction (control bit 18) |
| addr | input | 32 | Address to classify |
| rd_sel | input | 2 | Readback select |
| rd_data | output | 32 | Readback value |
| d_hit | output | 1 | Address falls in the data window |
| i_hit | output | 1 | Address falls in the instruction window |
| d_base | output | 32 | Data window base |
| d_mask | output | 32 | Data window mask |
| d_size | output | 33 | Data window size in bytes |
| i_base | output | 32 | Instruction window base |
| i_mask | output | 32 | Instruction window mask |
| i_size | output | 33 | Instruction window size in bytes |

## Verification
A corrupted setting register shows up right away on the readback port. Its effect on the window outputs and hit flags appears only once the next refresh has loaded the derived registers. If the sequencer fails to leave `ST_HOLD`, the derived outputs stay stale: one cycle after edge k+1 they still hold the old window, which the latency checks catch. Sweeping every exponent value on both sides covers the lower clamp, the saturation and the 4 GiB case where the mask collapses to zero. A mistake there appears as a wrong size or mask, and as wrong hits on the first and last byte of the window.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_REFRESH = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RD_DSET   = 2'd0,
        RD_ISET   = 2'd1,
        RD_SIZEID = 2'd2,
        RD_NONE   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W:0]   size;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] base;
    } geom_t;

endpackage

// File: rtl/tcm_setting_regs.sv
module tcm_setting_regs
    import tcm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] D_KEEP = 32'hFFFF_F03E,
    parameter logic [ADDR_W-1:0] I_KEEP = 32'h0000_003E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] d_set,
    output logic [ADDR_W-1:0] i_set
);

    localparam int unsigned N_REG = 2;

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] KEEP = (g == 0) ? D_KEEP : I_KEEP;
        localparam logic              SELV = (g != 0);
        logic [ADDR_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (sel == SELV)) begin
                q <= wdata & KEEP;
            end
        end
    end

    assign d_set = g_reg[0].q;
    assign i_set = g_reg[1].q;

endmodule

// File: rtl/tcm_geom.sv
module tcm_geom
    import tcm_pkg::*;
#(
    parameter int unsigned       UNIT_LOG2 = 9,
    parameter int unsigned       FIELD_W   = 5,
    parameter int unsigned       FIELD_LSB = 1,
    parameter int unsigned       FIELD_MAX = 23,
    parameter int unsigned       MIN_FIELD = 0,
    parameter logic [ADDR_W-1:0] BASE_KEEP = 32'hFFFF_F000
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] setting,
    output geom_t             geom
);

    localparam int unsigned    EW  = FIELD_W + 1;
    localparam int unsigned    SHW = 8;
    localparam logic [EW-1:0]  HI  = EW'(FIELD_MAX);

    logic [EW-1:0]     raw;
    logic [EW-1:0]     sat;
    logic [EW-1:0]     eff;
    logic [ADDR_W:0]   size_full;
    logic [ADDR_W-1:0] below;
    logic [ADDR_W-1:0] mask_c;

    always_comb begin
        raw = {1'b0, setting[FIELD_LSB +: FIELD_W]};
        sat = (raw > HI) ? HI : raw;
    end

    // The lower clamp exists only on a side that has a minimum size.
    if (MIN_FIELD > 0) begin : g_clamp
        localparam logic [EW-1:0] LO = EW'(MIN_FIELD);
        assign eff = (sat < LO) ? LO : sat;
    end else begin : g_noclamp
        assign eff = sat;
    end

    always_comb begin
        size_full = {{ADDR_W{1'b0}}, 1'b1} << (SHW'(UNIT_LOG2) + SHW'(eff));
        below     = size_full[ADDR_W-1:0] - ADDR_W'(1);
        mask_c    = BASE_KEEP & ~below;
        if (en) begin
            geom.en   = 1'b1;
            geom.size = size_full;
            geom.mask = mask_c;
            geom.base = setting & mask_c;
        end else begin
            geom.en   = 1'b0;
            geom.size = '0;
            geom.mask = '0;
            geom.base = '1;
        end
    end

endmodule

// File: rtl/tcm_hit.sv
module tcm_hit
    import tcm_pkg::*;
#(
    parameter bit LIMIT_MODE = 1'b0
) (
    input  geom_t             geom,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic in_win;

    if (LIMIT_MODE) begin : g_limit
        assign in_win = ({1'b0, addr} < geom.size) &&
                        ((addr & geom.mask) == geom.base);
    end else begin : g_match
        assign in_win = ((addr & geom.mask) == geom.base) &&
                        (geom.size != '0);
    end

    assign hit = geom.en && in_win;

endmodule

// File: rtl/tcm_decoder.sv
module tcm_decoder
    import tcm_pkg::*;
#(
    parameter int unsigned       UNIT_LOG2   = 9,
    parameter int unsigned       FIELD_W     = 5,
    parameter int unsigned       FIELD_LSB   = 1,
    parameter int unsigned       FIELD_MAX   = 23,
    parameter int unsigned       D_MIN_FIELD = 3,
    parameter logic [ADDR_W-1:0] D_KEEP      = 32'hFFFF_F03E,
    parameter logic [ADDR_W-1:0] I_KEEP      = 32'h0000_003E,
    parameter logic [ADDR_W-1:0] D_BASE_KEEP = 32'hFFFF_F000,
    parameter logic [ADDR_W-1:0] I_BASE_KEEP = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] SIZE_ID     = (32'd5 << 18) | (32'd6 << 6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [1:0]        tcm_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic              d_hit,
    output logic              i_hit,
    output logic [ADDR_W-1:0] d_base,
    output logic [ADDR_W-1:0] d_mask,
    output logic [ADDR_W:0]   d_size,
    output logic [ADDR_W-1:0] i_base,
    output logic [ADDR_W-1:0] i_mask,
    output logic [ADDR_W:0]   i_size
);

    logic [ADDR_W-1:0] d_set;
    logic [ADDR_W-1:0] i_set;
    logic [1:0]        en_q;
    logic              dirty;
    seq_state_e        state_q;
    seq_state_e        state_d;
    geom_t             d_geom_c;
    geom_t             i_geom_c;
    geom_t             d_geom_q;
    geom_t             i_geom_q;

    tcm_setting_regs #(
        .D_KEEP (D_KEEP),
        .I_KEEP (I_KEEP)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .d_set (d_set),
        .i_set (i_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= tcm_en;
    end

    assign dirty = cfg_we || (tcm_en != en_q);

    tcm_geom #(
        .UNIT_LOG2 (UNIT_LOG2),
        .FIELD_W   (FIELD_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_MAX (FIELD_MAX),
        .MIN_FIELD (D_MIN_FIELD),
        .BASE_KEEP (D_BASE_KEEP)
    ) u_dgeom (
        .en      (en_q[0]),
        .setting (d_set),
        .geom    (d_geom_c)
    );

    tcm_geom #(
        .UNIT_LOG2 (UNIT_LOG2),
        .FIELD_W   (FIELD_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_MAX (FIELD_MAX),
        .MIN_FIELD (0),
        .BASE_KEEP (I_BASE_KEEP)
    ) u_igeom (
        .en      (en_q[1]),
        .setting (i_set),
        .geom    (i_geom_c)
    );

    // Sequencer state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_HOLD;
        unique case (state_q)
            ST_LOAD:    state_d = dirty ? ST_REFRESH : ST_HOLD;
            ST_HOLD:    state_d = dirty ? ST_REFRESH : ST_HOLD;
            ST_REFRESH: state_d = dirty ? ST_REFRESH : ST_HOLD;
            default:    state_d = ST_LOAD;
        endcase
    end

    // Output process: derived windows load in ST_LOAD and ST_REFRESH.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_geom_q <= '{en: 1'b0, size: '0, mask: '0, base: '1};
            i_geom_q <= '{en: 1'b0, size: '0, mask: '0, base: '1};
        end else begin
            unique case (state_q)
                ST_LOAD, ST_REFRESH: begin
                    d_geom_q <= d_geom_c;
                    i_geom_q <= i_geom_c;
                end
                default: begin
                    d_geom_q <= d_geom_q;
                    i_geom_q <= i_geom_q;
                end
            endcase
        end
    end

    tcm_hit #(.LIMIT_MODE(1'b0)) u_dhit (
        .geom (d_geom_q),
        .addr (addr),
        .hit  (d_hit)
    );

    tcm_hit #(.LIMIT_MODE(1'b1)) u_ihit (
        .geom (i_geom_q),
        .addr (addr),
        .hit  (i_hit)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_sel_e'(rd_sel))
            RD_DSET:   rd_data = d_set;
            RD_ISET:   rd_data = i_set;
            RD_SIZEID: rd_data = SIZE_ID;
            RD_NONE:   rd_data = '0;
            default:   rd_data = '0;
        endcase
    end

    assign d_base = d_geom_q.base;
    assign d_mask = d_geom_q.mask;
    assign d_size = d_geom_q.size;
    assign i_base = i_geom_q.base;
    assign i_mask = i_geom_q.mask;
    assign i_size = i_geom_q.size;

endmodule

// File: rtl/tcm_decoder_chk.sv
module tcm_decoder_chk
    import tcm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rd_sel,
    input logic [ADDR_W-1:0] rd_data,
    input logic [ADDR_W-1:0] i_set,
    input seq_state_e        state_q,
    input logic              d_hit,
    input logic              i_hit,
    input logic [ADDR_W-1:0] d_base,
    input logic [ADDR_W-1:0] d_mask,
    input logic [ADDR_W:0]   d_size,
    input logic [ADDR_W-1:0] i_base,
    input logic [ADDR_W:0]   i_size
);

    p_size_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> (rd_data == 32'h0014_0180));

    p_iset_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_set & ~32'h0000_003E) == '0);

    p_dsize_pow2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_size != '0) |-> (($countones(d_size) == 1) && (d_size >= 33'h1000)));

    p_dbase_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_size != '0) |-> ((d_base & ~d_mask) == '0));

    p_dhit_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d_hit |-> (d_size != '0));

    p_ihit_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        i_hit |-> ((i_size != '0) && (i_base == '0)));

    p_dpark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_size == '0) |-> ((d_base == '1) && (d_mask == '0)));

    p_refresh_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(d_size) || !$stable(d_base) || !$stable(i_size))
            |-> ($past(state_q) != ST_HOLD));

endmodule

bind tcm_decoder tcm_decoder_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .i_set   (i_set),
    .state_q (state_q),
    .d_hit   (d_hit),
    .i_hit   (i_hit),
    .d_base  (d_base),
    .d_mask  (d_mask),
    .d_size  (d_size),
    .i_base  (i_base),
    .i_size  (i_size)
);

// File: tb/tcm_decoder_tb_top.sv
`timescale 1ns/1ps
module tcm_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  tcm_en = 2'b00;
    logic [31:0] addr = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        d_hit, i_hit;
    logic [31:0] d_base, d_mask, i_base, i_mask;
    logic [32:0] d_size, i_size;

    int n_vec = 0;
    int n_bad = 0;

    // Model of the stored settings, the enables and the expected windows.
    logic [31:0] m_dset = '0, m_iset = '0;
    logic [1:0]  m_en = 2'b00;
    logic [31:0] e_dbase = '1, e_dmask = '0, e_ibase = '1, e_imask = '0;
    logic [32:0] e_dsize = '0, e_isize = '0;

    always #10 clk = ~clk;

    tcm_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tcm_en(tcm_en), .addr(addr), .rd_sel(rd_sel),
        .rd_data(rd_data), .d_hit(d_hit), .i_hit(i_hit),
        .d_base(d_base), .d_mask(d_mask), .d_size(d_size),
        .i_base(i_base), .i_mask(i_mask), .i_size(i_size)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] exp_size(input logic [4:0] f, input int lo);
        int e;
        e = int'(f);
        if (e > 23) e = 23;
        if (e < lo) e = lo;
        return 33'(1) << (9 + e);
    endfunction

    task automatic update_model();
        if (m_en[0]) begin
            e_dsize = exp_size(m_dset[5:1], 3);
            e_dmask = 32'hFFFF_F000 & ~(e_dsize[31:0] - 32'd1);
            e_dbase = m_dset & e_dmask;
        end else begin
            e_dsize = '0; e_dmask = '0; e_dbase = '1;
        end
        if (m_en[1]) begin
            e_isize = exp_size(m_iset[5:1], 0);
            e_imask = '0; e_ibase = '0;
        end else begin
            e_isize = '0; e_imask = '0; e_ibase = '1;
        end
    endtask

    task automatic check_windows(input string req);
        chk({req, " d_size"}, 64'(d_size), 64'(e_dsize));
        chk({req, " d_mask"}, 64'(d_mask), 64'(e_dmask));
        chk({req, " d_base"}, 64'(d_base), 64'(e_dbase));
        chk({req, " i_size"}, 64'(i_size), 64'(e_isize));
        chk({req, " i_mask"}, 64'(i_mask), 64'(e_imask));
        chk({req, " i_base"}, 64'(i_base), 64'(e_ibase));
    endtask

    task automatic probe(input string req, input logic [31:0] a);
        logic ed, ei;
        addr = a;
        #1;
        ed = m_en[0] && ((a & e_dmask) == e_dbase);
        ei = m_en[1] && ({1'b0, a} < e_isize);
        chk({req, " d_hit"}, 64'(d_hit), 64'(ed));
        chk({req, " i_hit"}, 64'(i_hit), 64'(ei));
    endtask

    task automatic read_chk(input string req, input logic [1:0] s, input logic [31:0] exp);
        rd_sel = s;
        #1;
        chk(req, 64'(rd_data), 64'(exp));
    endtask

    // Write, confirm old windows after the write edge (R10), then new ones.
    task automatic do_write(input logic sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check_windows("R10 old after write");
        if (sel) m_iset = v & 32'h0000_003E;
        else     m_dset = v & 32'hFFFF_F03E;
        @(negedge clk);
        update_model();
    endtask

    task automatic set_en(input logic [1:0] en);
        @(negedge clk);
        tcm_en = en;
        @(negedge clk);
        check_windows("R10 old after enable change");
        m_en = en;
        @(negedge clk);
        update_model();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk("R1 dset reset", 2'd0, 32'h0);
        read_chk("R1 iset reset", 2'd1, 32'h0);
        check_windows("R1 parked");
        probe("R1", 32'h0000_0000);
        probe("R1", 32'hFFFF_FFFF);

        // R4: readback map
        read_chk("R4 size id", 2'd2, 32'h0014_0180);
        read_chk("R4 unused sel", 2'd3, 32'h0);

        // R9: enable both; field 0 gives 4 KiB data, 512 B instruction
        set_en(2'b11);
        check_windows("R9 enable");
        probe("R9", 32'h0000_0000);
        probe("R9", 32'h0000_0200);

        // R2 R5 R6 R7: sweep every data exponent value
        for (int f = 0; f < 32; f++) begin
            logic [31:0] v;
            logic [32:0] isz_before;
            v = (32'h9E37_79B9 * 32'(f + 1));
            v[5:1] = 5'(f);
            isz_before = e_isize;
            do_write(1'b0, v);
            read_chk("R2 dset readback", 2'd0, v & 32'hFFFF_F03E);
            check_windows("R5/R6 data window");
            chk("R2 instr window untouched", 64'(i_size), 64'(isz_before));
            probe("R7 base", e_dbase);
            probe("R7 last byte", e_dbase + (e_dsize[31:0] - 32'd1));
            probe("R7 outside", e_dbase ^ 32'h8000_0000);
            probe("R7 below", e_dbase - 32'd1);
        end

        // R3 R8: sweep every instruction exponent value
        for (int f = 0; f < 32; f++) begin
            logic [31:0] v;
            logic [32:0] dsz_before;
            v = 32'hFFFF_FFFF;
            v[5:1] = 5'(f);
            dsz_before = e_dsize;
            do_write(1'b1, v);
            read_chk("R3 iset readback", 2'd1, 32'(f) << 1);
            check_windows("R8 instr window");
            chk("R3 data window untouched", 64'(d_size), 64'(dsz_before));
            probe("R8 last byte", e_isize[31:0] - 32'd1);
            probe("R8 end", e_isize[31:0]);
            probe("R8 top", 32'hFFFF_FFFF);
        end

        // Put a small data window at a known base for the enable tests.
        do_write(1'b0, 32'h0280_0000 | (32'd5 << 1));
        do_write(1'b1, 32'd4 << 1);
        check_windows("R5/R6 16K window");
        probe("R7 in window", 32'h0280_3FFC);
        probe("R7 past window", 32'h0280_4000);

        // R9: data disabled alone, then instruction too, then both back
        set_en(2'b10);
        check_windows("R9 data parked");
        probe("R9 data off", 32'h0280_0000);
        probe("R9 instr on", 32'h0000_1000);
        read_chk("R9 dset kept", 2'd0, 32'h0280_000A);
        set_en(2'b00);
        check_windows("R9 both parked");
        probe("R9 both off", 32'h0000_0000);
        set_en(2'b11);
        check_windows("R9 restored");
        probe("R9 restored", 32'h0280_0010);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule